// File: doc/BRIEF.md
# Two-Side Parallel Port Register File

This block is the processor-facing register set of a two-sided parallel interface adapter. A processor reaches it through three chip-select lines, two register-select lines, a read/write line and a bus-cycle strobe on a synchronous clock. Each side (A and B) holds a control register, a direction register and an output register. Together these drive one 8-bit peripheral port per side, with direction chosen per line. The port is modelled as separate drive, drive-enable and pin-sample vectors rather than as tri-state nets.

On each side one address is shared between the direction register and the data path, and bit 2 of that side's control register picks between them. The upper two control bits are not stored here. They come in as status from the neighbouring interrupt and control-line logic, which in turn receives the low control bits and two one-cycle event strobes: a data read on side A and a data write on side B. Readback differs by side. Side A returns the live pin levels on all lines. Side B returns the output register on output lines and the pin on input lines. A write is captured while the bus cycle is active and reaches its register only once the cycle has ended.

Top module: `pia_regfile`

## Requirements
- R1: The block is selected only when `sel0_i`=1, `sel1_i`=1 and `sel2_n_i`=0. Otherwise `rdata_oe_o` stays 0, and a write cycle changes no register and no port output.
- R2: `rsel_i[1]` picks the side (0 = A, 1 = B). `rsel_i[0]`=1 addresses that side's control register, so the A and B control registers read back independently.
- R3: With `rsel_i[0]`=0, control bit 2 = 1 addresses the data path and control bit 2 = 0 addresses the direction register. The direction register reads back as written.
- R4: `pX_oe_o` equals the side's direction register and `pX_out_o` equals its output register. A direction bit of 1 makes a line an output, and 0 makes it an input. Directions may be mixed within a port.
- R5: While `rst_n` is low, every register is 0. So all outputs, enables, control bits and strobes are 0. Reset is released on the third rising edge after `rst_n` rises.
- R6: A side-A data read returns `pa_in_i` on all 8 bits, whatever the direction bits are.
- R7: A side-B data read returns bit i as `pb_out_o[i]` where the direction bit is 1, and as `pb_in_i[i]` where it is 0.
- R8: A write is captured on each rising edge where the access is active (the last captured data wins). It commits on the first rising edge where the access is no longer active. Port outputs never change at an edge where the access is active.
- R9: A control read returns {status[1:0], control[5:0]}, with the status taken from `stat_a_i`/`stat_b_i`. A write to a control register changes only bits 5:0.
- R10: After a side-A data read cycle ends, `rd_a_stb_o` is 1 for exactly one clock cycle. It rises on the same edge on which a write would have committed.
- R11: After a side-B data write cycle ends, `wr_b_stb_o` is 1 for exactly one clock cycle, starting at the edge where the output register takes the new value.
- R12: `rdata_oe_o` is 1, combinationally, exactly while `cyc_i`=1, the block is selected and `rd_i`=1. Read data is valid during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0_i | input | 1 | Chip select, active high |
| sel1_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Chip select, active low |
| cyc_i | input | 1 | Bus cycle active strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| rsel_i | input | 2 | Register select: bit 1 side, bit 0 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (0 when not driving) |
| rdata_oe_o | output | 1 | Read data drive enable |
| stat_a_i | input | 2 | Side-A status shown as control bits 7:6 |
| stat_b_i | input | 2 | Side-B status shown as control bits 7:6 |
| ctl_a_o | output | 6 | Side-A control bits 5:0 |
| ctl_b_o | output | 6 | Side-B control bits 5:0 |
| rd_a_stb_o | output | 1 | One-cycle strobe after a side-A data read |
| wr_b_stb_o | output | 1 | One-cycle strobe after a side-B data write |
| pa_out_o | output | 8 | Side-A port drive values |
| pa_oe_o | output | 8 | Side-A per-line drive enable |
| pa_in_i | input | 8 | Side-A pin levels |
| pb_out_o | output | 8 | Side-B port drive values |
| pb_oe_o | output | 8 | Side-B per-line drive enable |
| pb_in_i | input | 8 | Side-B pin levels |

## Verification
Read data and its enable respond in the same cycle as the bus inputs, so the bench compares them shortly after it drives new inputs. A write reaches the ports, and both strobes rise, one edge after the last active-access edge. That means two edges after a single-cycle access begins. The bench's reference model applies its updates on that same edge and is compared against every output just after each falling edge. Directed checks confirm that port outputs stay frozen across a held multi-cycle access, and that each strobe falls again after exactly one cycle.

// File: rtl/pia_pkg.sv
package pia_pkg;
  // number of control-register bits supplied from outside as status
  localparam int unsigned STAT_BITS  = 2;
  // control bit choosing data path (1) or direction register (0)
  localparam int unsigned DIRSEL_POS = 2;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_DATA_A = 3'd1,
    TGT_DIR_A  = 3'd2,
    TGT_CTL_A  = 3'd3,
    TGT_DATA_B = 3'd4,
    TGT_DIR_B  = 3'd5,
    TGT_CTL_B  = 3'd6
  } reg_tgt_e;
endpackage

// File: rtl/pia_decode.sv
module pia_decode
  import pia_pkg::*;
(
  input  logic     sel0_i,
  input  logic     sel1_i,
  input  logic     sel2_n_i,
  input  logic     cyc_i,
  input  logic     rd_i,
  input  logic [1:0] rsel_i,
  input  logic     dirsel_a_i,
  input  logic     dirsel_b_i,
  output logic     chip_sel_o,
  output logic     acc_o,
  output logic     rd_en_o,
  output reg_tgt_e tgt_o
);
  reg_tgt_e tgt_raw;

  always_comb begin
    chip_sel_o = sel0_i & sel1_i & ~sel2_n_i;
    acc_o      = cyc_i & chip_sel_o;
    rd_en_o    = acc_o & rd_i;
  end

  always_comb begin
    unique case (rsel_i)
      2'b00:   tgt_raw = dirsel_a_i ? TGT_DATA_A : TGT_DIR_A;
      2'b01:   tgt_raw = TGT_CTL_A;
      2'b10:   tgt_raw = dirsel_b_i ? TGT_DATA_B : TGT_DIR_B;
      default: tgt_raw = TGT_CTL_B;
    endcase
    tgt_o = acc_o ? tgt_raw : TGT_NONE;
  end
endmodule

// File: rtl/pia_xfer.sv
module pia_xfer
  import pia_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          rd_i,
  input  reg_tgt_e      tgt_i,
  input  logic [DW-1:0] wdata_i,
  output reg_tgt_e      wr_tgt_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_a_stb_o,
  output logic          wr_b_stb_o
);
  logic          pend_q, pend_d;
  logic          rd_q, rd_d;
  reg_tgt_e      tgt_q, tgt_d;
  logic [DW-1:0] data_q, data_d;
  logic          rda_q, rda_d;
  logic          wrb_q, wrb_d;
  logic          commit;

  always_comb begin
    pend_d = acc_i;
    rd_d   = rd_q;
    tgt_d  = tgt_q;
    data_d = data_q;
    if (acc_i) begin
      rd_d   = rd_i;
      tgt_d  = tgt_i;
      data_d = wdata_i;
    end
    commit = pend_q & ~acc_i;
    rda_d  = commit & rd_q  & (tgt_q == TGT_DATA_A);
    wrb_d  = commit & ~rd_q & (tgt_q == TGT_DATA_B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      tgt_q  <= TGT_NONE;
      data_q <= '0;
      rda_q  <= 1'b0;
      wrb_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rd_q   <= rd_d;
      tgt_q  <= tgt_d;
      data_q <= data_d;
      rda_q  <= rda_d;
      wrb_q  <= wrb_d;
    end
  end

  assign wr_tgt_o   = (commit && !rd_q) ? tgt_q : TGT_NONE;
  assign wdata_o    = data_q;
  assign rd_a_stb_o = rda_q;
  assign wr_b_stb_o = wrb_q;

  // R8
  commit_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tgt_o != TGT_NONE) |-> ($past(acc_i) && !acc_i));
  // R10
  rd_a_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_stb_o |=> !rd_a_stb_o);
  // R11
  wr_b_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b_stb_o |=> !wr_b_stb_o);
endmodule

// File: rtl/pia_side.sv
module pia_side
  import pia_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter bit          OUT_READ  = 1'b0,
  localparam int unsigned CTLW     = DW - STAT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_ctl_i,
  input  logic                 we_dir_i,
  input  logic                 we_out_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [STAT_BITS-1:0] stat_i,
  input  logic [DW-1:0]        pin_i,
  output logic [CTLW-1:0]      ctl_o,
  output logic [DW-1:0]        dir_o,
  output logic [DW-1:0]        out_o,
  output logic [DW-1:0]        rd_ctl_o,
  output logic [DW-1:0]        rd_dir_o,
  output logic [DW-1:0]        rd_data_o
);
  logic [CTLW-1:0] ctl_q, ctl_d;
  logic [DW-1:0]   dir_q, dir_d;
  logic [DW-1:0]   out_q, out_d;

  always_comb begin
    ctl_d = ctl_q;
    dir_d = dir_q;
    out_d = out_q;
    if (we_ctl_i) ctl_d = wdata_i[CTLW-1:0];
    if (we_dir_i) dir_d = wdata_i;
    if (we_out_i) out_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dir_q <= '0;
      out_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_rd
    if (OUT_READ) begin : g_mixed
      assign rd_data_o[i] = dir_q[i] ? out_q[i] : pin_i[i];
    end else begin : g_pins
      assign rd_data_o[i] = pin_i[i];
    end
  end

  assign ctl_o    = ctl_q;
  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign rd_ctl_o = {stat_i, ctl_q};
  assign rd_dir_o = dir_q;

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dir_i |=> $stable(dir_o));
endmodule

// File: rtl/pia_regfile.sv
module pia_regfile
  import pia_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned CTLW = DW - STAT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel0_i,
  input  logic                 sel1_i,
  input  logic                 sel2_n_i,
  input  logic                 cyc_i,
  input  logic                 rd_i,
  input  logic [1:0]           rsel_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 rdata_oe_o,
  input  logic [STAT_BITS-1:0] stat_a_i,
  input  logic [STAT_BITS-1:0] stat_b_i,
  output logic [CTLW-1:0]      ctl_a_o,
  output logic [CTLW-1:0]      ctl_b_o,
  output logic                 rd_a_stb_o,
  output logic                 wr_b_stb_o,
  output logic [DW-1:0]        pa_out_o,
  output logic [DW-1:0]        pa_oe_o,
  input  logic [DW-1:0]        pa_in_i,
  output logic [DW-1:0]        pb_out_o,
  output logic [DW-1:0]        pb_oe_o,
  input  logic [DW-1:0]        pb_in_i
);
  logic          rst_s1_q, rst_s2_q;
  logic          chip_sel, acc, rd_en;
  reg_tgt_e      tgt, wr_tgt;
  logic [DW-1:0] wdata_c;
  logic [DW-1:0] a_rd_ctl, a_rd_dir, a_rd_data;
  logic [DW-1:0] b_rd_ctl, b_rd_dir, b_rd_data;
  logic [DW-1:0] rd_mux;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  pia_decode u_dec (
    .sel0_i     (sel0_i),
    .sel1_i     (sel1_i),
    .sel2_n_i   (sel2_n_i),
    .cyc_i      (cyc_i),
    .rd_i       (rd_i),
    .rsel_i     (rsel_i),
    .dirsel_a_i (ctl_a_o[DIRSEL_POS]),
    .dirsel_b_i (ctl_b_o[DIRSEL_POS]),
    .chip_sel_o (chip_sel),
    .acc_o      (acc),
    .rd_en_o    (rd_en),
    .tgt_o      (tgt)
  );

  pia_xfer #(.DW(DW)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .acc_i      (acc),
    .rd_i       (rd_i),
    .tgt_i      (tgt),
    .wdata_i    (wdata_i),
    .wr_tgt_o   (wr_tgt),
    .wdata_o    (wdata_c),
    .rd_a_stb_o (rd_a_stb_o),
    .wr_b_stb_o (wr_b_stb_o)
  );

  pia_side #(.DW(DW), .OUT_READ(1'b0)) u_side_a (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .we_ctl_i  (wr_tgt == TGT_CTL_A),
    .we_dir_i  (wr_tgt == TGT_DIR_A),
    .we_out_i  (wr_tgt == TGT_DATA_A),
    .wdata_i   (wdata_c),
    .stat_i    (stat_a_i),
    .pin_i     (pa_in_i),
    .ctl_o     (ctl_a_o),
    .dir_o     (pa_oe_o),
    .out_o     (pa_out_o),
    .rd_ctl_o  (a_rd_ctl),
    .rd_dir_o  (a_rd_dir),
    .rd_data_o (a_rd_data)
  );

  pia_side #(.DW(DW), .OUT_READ(1'b1)) u_side_b (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .we_ctl_i  (wr_tgt == TGT_CTL_B),
    .we_dir_i  (wr_tgt == TGT_DIR_B),
    .we_out_i  (wr_tgt == TGT_DATA_B),
    .wdata_i   (wdata_c),
    .stat_i    (stat_b_i),
    .pin_i     (pb_in_i),
    .ctl_o     (ctl_b_o),
    .dir_o     (pb_oe_o),
    .out_o     (pb_out_o),
    .rd_ctl_o  (b_rd_ctl),
    .rd_dir_o  (b_rd_dir),
    .rd_data_o (b_rd_data)
  );

  always_comb begin
    unique case (tgt)
      TGT_DATA_A: rd_mux = a_rd_data;
      TGT_DIR_A:  rd_mux = a_rd_dir;
      TGT_CTL_A:  rd_mux = a_rd_ctl;
      TGT_DATA_B: rd_mux = b_rd_data;
      TGT_DIR_B:  rd_mux = b_rd_dir;
      TGT_CTL_B:  rd_mux = b_rd_ctl;
      default:    rd_mux = '0;
    endcase
    rdata_o    = rd_en ? rd_mux : '0;
    rdata_oe_o = rd_en;
  end

  // R1
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !chip_sel |-> !rdata_oe_o);
  // R8
  ports_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $past(acc) |-> ($stable(pa_out_o) && $stable(pb_out_o) &&
                    $stable(pa_oe_o) && $stable(pb_oe_o)));
endmodule

// File: tb/tb_pia_regfile.sv
`timescale 1ns/1ps
module tb_pia_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel0 = 1'b0, sel1 = 1'b0, sel2_n = 1'b1;
  logic       cyc = 1'b0, rd = 1'b0;
  logic [1:0] rsel = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [1:0] stat_a = 2'b00, stat_b = 2'b00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic       rdata_oe, rd_a_stb, wr_b_stb;
  logic [5:0] ctl_a, ctl_b;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pia_regfile dut (
    .clk(clk), .rst_n(rst_n), .sel0_i(sel0), .sel1_i(sel1), .sel2_n_i(sel2_n),
    .cyc_i(cyc), .rd_i(rd), .rsel_i(rsel), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .stat_a_i(stat_a), .stat_b_i(stat_b),
    .ctl_a_o(ctl_a), .ctl_b_o(ctl_b), .rd_a_stb_o(rd_a_stb), .wr_b_stb_o(wr_b_stb),
    .pa_out_o(pa_out), .pa_oe_o(pa_oe), .pa_in_i(pa_in),
    .pb_out_o(pb_out), .pb_oe_o(pb_oe), .pb_in_i(pb_in)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ctl [2];
  logic [7:0] m_dir [2];
  logic [7:0] m_out [2];
  bit         m_rda, m_wrb;
  bit         p_val, p_rd;
  int         p_side, p_kind;   // kind: 0 dir, 1 data, 2 control
  logic [7:0] p_data;
  int         rcnt = 0;

  function automatic bit sel_ok();
    return sel0 && sel1 && !sel2_n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) rcnt = 0;
    else if (rcnt < 3) rcnt++;
    m_rda = 1'b0;
    m_wrb = 1'b0;
    if (rcnt < 3) begin
      for (int s = 0; s < 2; s++) begin
        m_ctl[s] = 8'h00; m_dir[s] = 8'h00; m_out[s] = 8'h00;
      end
      p_val = 1'b0;
    end else if (cyc && sel_ok()) begin
      p_val  = 1'b1;
      p_rd   = rd;
      p_side = rsel[1];
      p_kind = rsel[0] ? 2 : (m_ctl[rsel[1]][2] ? 1 : 0);
      p_data = wdata;
    end else if (p_val) begin
      p_val = 1'b0;
      if (!p_rd) begin
        if (p_kind == 2)      m_ctl[p_side] = {2'b00, p_data[5:0]};
        else if (p_kind == 1) m_out[p_side] = p_data;
        else                  m_dir[p_side] = p_data;
      end
      m_rda = p_rd && p_side == 0 && p_kind == 1;
      m_wrb = !p_rd && p_side == 1 && p_kind == 1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      logic [7:0] exp_rd;
      int s;
      bit exp_oe;
      s = rsel[1];
      exp_oe = cyc && sel_ok() && rd;
      chk("R4 pa_out", pa_out, m_out[0]);
      chk("R4 pa_oe",  pa_oe,  m_dir[0]);
      chk("R4 pb_out", pb_out, m_out[1]);
      chk("R4 pb_oe",  pb_oe,  m_dir[1]);
      chk("R9 ctl_a",  {2'b00, ctl_a}, m_ctl[0]);
      chk("R9 ctl_b",  {2'b00, ctl_b}, m_ctl[1]);
      chk("R10 rd_a_stb", {7'd0, rd_a_stb}, {7'd0, m_rda});
      chk("R11 wr_b_stb", {7'd0, wr_b_stb}, {7'd0, m_wrb});
      chk(sel_ok() ? "R12 rdata_oe" : "R1 rdata_oe", {7'd0, rdata_oe}, {7'd0, exp_oe});
      if (exp_oe) begin
        if (rsel[0]) begin
          exp_rd = {(s == 0) ? stat_a : stat_b, m_ctl[s][5:0]};
          chk("R9 ctl read", rdata, exp_rd);
        end else if (!m_ctl[s][2]) begin
          chk("R3 dir read", rdata, m_dir[s]);
        end else if (s == 0) begin
          chk("R6 A read", rdata, pa_in);
        end else begin
          exp_rd = (m_dir[1] & m_out[1]) | (~m_dir[1] & pb_in);
          chk("R7 B read", rdata, exp_rd);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(input logic [1:0] rs, input logic [7:0] d);
    @(negedge clk);
    sel0 = 1; sel1 = 1; sel2_n = 0; cyc = 1; rd = 0; rsel = rs; wdata = d;
    @(negedge clk);
    cyc = 0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] rs, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel0 = 1; sel1 = 1; sel2_n = 0; cyc = 1; rd = 1; rsel = rs;
    #2;
    chk(tag, rdata, exp);
    @(negedge clk);
    cyc = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #2;
    // R5 reset state
    chk("R5 pa_oe", pa_oe, 8'h00);
    chk("R5 pb_oe", pb_oe, 8'h00);
    chk("R5 pa_out", pa_out, 8'h00);
    chk("R5 ctl_b", {2'b00, ctl_b}, 8'h00);
    mon_on = 1;

    // R3 / R4: direction A then select data path
    bus_wr(2'b00, 8'hF0);
    bus_rd(2'b00, 8'hF0, "R3 dir A readback");
    bus_wr(2'b01, 8'h04);
    bus_wr(2'b00, 8'hA5);
    #2;
    chk("R4 pa_out", pa_out, 8'hA5);
    chk("R4 pa_oe mixed", pa_oe, 8'hF0);

    // R6 + R10
    pa_in = 8'h3C;
    bus_rd(2'b00, 8'h3C, "R6 pins on all bits");
    #2;
    chk("R10 strobe high", {7'd0, rd_a_stb}, 8'h01);
    @(negedge clk); #2;
    chk("R10 strobe one cycle", {7'd0, rd_a_stb}, 8'h00);

    // side B: R7 + R11
    bus_wr(2'b10, 8'h0F);
    bus_wr(2'b11, 8'h3F);
    @(negedge clk);
    sel0 = 1; sel1 = 1; sel2_n = 0; cyc = 1; rd = 0; rsel = 2'b10; wdata = 8'h5A;
    @(negedge clk); cyc = 0;
    @(negedge clk); #2;
    chk("R11 strobe with update", {7'd0, wr_b_stb}, 8'h01);
    chk("R11 orb updated", pb_out, 8'h5A);
    @(negedge clk); #2;
    chk("R11 strobe one cycle", {7'd0, wr_b_stb}, 8'h00);
    pb_in = 8'hC3;
    bus_rd(2'b10, 8'hCA, "R7 mixed readback");

    // R9 status bits and write masking; R2 side independence
    stat_a = 2'b11;
    bus_rd(2'b01, 8'hC4, "R9 status in ctl A");
    bus_wr(2'b01, 8'hFF);
    stat_a = 2'b01;
    bus_rd(2'b01, 8'h7F, "R9 write bits 5:0 only");
    stat_b = 2'b10;
    bus_rd(2'b11, 8'hBF, "R2 ctl B separate from A");

    // R1 unselected write ignored
    @(negedge clk);
    sel0 = 0; sel1 = 1; sel2_n = 0; cyc = 1; rd = 0; rsel = 2'b00; wdata = 8'h00;
    @(negedge clk); cyc = 0;
    @(negedge clk); sel0 = 1; sel2_n = 1; cyc = 1; rd = 1;
    #2;
    chk("R1 no drive when unselected", {7'd0, rdata_oe}, 8'h00);
    @(negedge clk); cyc = 0; sel2_n = 0;
    #2;
    chk("R1 write ignored", pa_out, 8'hA5);

    // R8 held access: last data wins, ports frozen until end
    @(negedge clk);
    sel0 = 1; sel1 = 1; sel2_n = 0; cyc = 1; rd = 0; rsel = 2'b00; wdata = 8'h11;
    @(negedge clk); wdata = 8'h22; #2;
    chk("R8 frozen during access", pa_out, 8'hA5);
    @(negedge clk); wdata = 8'h33; #2;
    chk("R8 frozen during access", pa_out, 8'hA5);
    @(negedge clk); cyc = 0; #2;
    chk("R8 not yet committed", pa_out, 8'hA5);
    @(negedge clk); #2;
    chk("R8 last data committed", pa_out, 8'h33);

    // R3 clear select bit: address returns direction register
    bus_wr(2'b01, 8'h00);
    bus_rd(2'b00, 8'hF0, "R3 dir after bit2 clear");

    // randomized traffic against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      sel0   = ($urandom_range(0, 7) != 0);
      sel1   = ($urandom_range(0, 7) != 0);
      sel2_n = ($urandom_range(0, 7) == 0);
      cyc    = $urandom_range(0, 1);
      rd     = $urandom_range(0, 1);
      rsel   = 2'($urandom_range(0, 3));
      wdata  = 8'($urandom);
      stat_a = 2'($urandom);
      stat_b = 2'($urandom);
      pa_in  = 8'($urandom);
      pb_in  = 8'($urandom);
    end
    @(negedge clk); cyc = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule